// File: doc/BRIEF.md
# Concurrent Self-Test Pattern-Matching Controller

This block runs a self-test of a combinational circuit while that circuit keeps doing its normal job. It holds a pending pseudo-random test vector in a maximal-length shift-register generator and compares it every cycle with the vector actually presented to the circuit. Whenever live traffic happens to equal the pending vector, the circuit's response to it is folded into a multiple-input signature register and the generator steps to its next vector.

If traffic does not produce a match within a programmable number of cycles, the block takes over the circuit's inputs for a single cycle through an input multiplexer. It drives the pending vector, captures the response, and hands the inputs back to functional traffic. A session is launched with a start pulse that samples the waiting limit and the number of vectors to apply. Once that many vectors have been applied, the block raises done and holds the final signature for comparison with a known-good value.

Top module: `cbist_match_ctrl`

## Requirements
- R1: After reset, done is 0, test_sel is 0, signature is 0 and cut_in equals func_in.
- R2: Whenever test_sel is 0, cut_in equals func_in; whenever test_sel is 1, cut_in equals the pending test vector.
- R3: During a run, a cycle in which cut_in equals the pending vector is an applied cycle: the response is compacted and the generator advances at the next edge.
- R4: The generator is seeded with 0x01 at start and steps as next = {p[6:0], p[7]^p[5]^p[4]^p[3]} (polynomial x^8+x^6+x^5+x^4+1).
- R5: The signature is cleared to 0 at start; on each applied cycle it becomes step(signature) XOR cut_resp, with the same step rule as R4.
- R6: After L consecutive non-matching run cycles (L = cfg_wait_limit sampled at start; 0 and 1 both mean one cycle), test_sel is 1 in the following cycle.
- R7: test_sel stays high for exactly one cycle; that cycle is an applied cycle and test_sel returns to 0 afterwards.
- R8: An applied cycle restarts the waiting count, so a full window of L misses is needed again before the next forced cycle.
- R9: After N applied cycles (N = cfg_num_patterns sampled at start), done is 1 from the next cycle on, the signature holds, test_sel stays 0 and cut_in follows func_in.
- R10: A start pulse in any state restarts the session (seed, cleared signature, counts, new configuration); with N = 0, done is 1 in the next cycle with signature 0.
- R11: A non-matching run cycle leaves the signature unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a session |
| cfg_wait_limit | input | LIM_W | Non-matching cycles before a forced vector, sampled at start |
| cfg_num_patterns | input | CNT_W | Vectors to apply in the session, sampled at start |
| func_in | input | W | Functional input vector from the system |
| cut_resp | input | W | Response of the circuit under test to cut_in |
| cut_in | output | W | Vector driven into the circuit under test (multiplexer output) |
| test_sel | output | 1 | 1 while the test vector is forced onto the circuit |
| signature | output | W | Compacted response signature |
| done | output | 1 | Session complete; signature final |

## Verification
A wrong generator state shows up at cut_in on the next forced cycle, at most L+1 cycles later, and changes which functional vectors count as matches. A wrong signature or compaction step shows at the signature port on the very next applied cycle. A miscounted waiting window moves the test_sel pulse by a cycle, and a miscounted vector total makes done rise early or late. The bench predicts every cycle's cut_in, test_sel, signature and done, so each of these faults is flagged within a few cycles.

// File: rtl/cbist_pkg.sv
package cbist_pkg;
    localparam int PAT_W = 8;
    localparam logic [PAT_W-1:0] PAT_TAPS = 8'hB8;
    localparam logic [PAT_W-1:0] PAT_SEED = 8'h01;
    localparam int LIMIT_W = 8;
    localparam int COUNT_W = 16;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;
endpackage

// File: rtl/cbist_lfsr.sv
module cbist_lfsr #(
    parameter int              W    = cbist_pkg::PAT_W,
    parameter logic [W-1:0]    TAPS = cbist_pkg::PAT_TAPS,
    parameter logic [W-1:0]    SEED = cbist_pkg::PAT_SEED
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] pattern
);
    logic [W-1:0] pat_d, pat_q;

    function automatic logic [W-1:0] shift_once(input logic [W-1:0] x);
        return {x[W-2:0], ^(x & TAPS)};
    endfunction

    always_comb begin
        pat_d = pat_q;
        if (load)      pat_d = SEED;
        else if (step) pat_d = shift_once(pat_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pat_q <= SEED;
        else        pat_q <= pat_d;
    end

    assign pattern = pat_q;

    // R4: a maximal-length generator with nonzero seed never reaches zero
    p_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pat_q != '0);
endmodule

// File: rtl/cbist_misr.sv
module cbist_misr #(
    parameter int           W    = cbist_pkg::PAT_W,
    parameter logic [W-1:0] TAPS = cbist_pkg::PAT_TAPS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         capture,
    input  logic [W-1:0] resp,
    output logic [W-1:0] sig
);
    logic [W-1:0] sig_d, sig_q;

    function automatic logic [W-1:0] shift_once(input logic [W-1:0] x);
        return {x[W-2:0], ^(x & TAPS)};
    endfunction

    always_comb begin
        sig_d = sig_q;
        if (clear)        sig_d = '0;
        else if (capture) sig_d = shift_once(sig_q) ^ resp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= '0;
        else        sig_q <= sig_d;
    end

    assign sig = sig_q;

    // R11: without clear or capture the signature holds
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !capture) |=> sig_q == $past(sig_q));
endmodule

// File: rtl/cbist_wait_timer.sv
module cbist_wait_timer #(
    parameter int LIM_W = cbist_pkg::LIMIT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [LIM_W-1:0] limit,
    output logic             expire
);
    logic [LIM_W-1:0] wait_d, wait_q;
    logic [LIM_W:0]   next_cnt;

    assign next_cnt = {1'b0, wait_q} + {{LIM_W{1'b0}}, 1'b1};
    assign expire   = tick && !clear && (next_cnt >= {1'b0, limit});

    always_comb begin
        wait_d = wait_q;
        if (clear || expire) wait_d = '0;
        else if (tick)       wait_d = next_cnt[LIM_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wait_q <= '0;
        else        wait_q <= wait_d;
    end

    // R6: an expiry restarts the window
    p_expire_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> wait_q == '0);
endmodule

// File: rtl/cbist_match_ctrl.sv
module cbist_match_ctrl #(
    parameter int           W     = cbist_pkg::PAT_W,
    parameter logic [W-1:0] TAPS  = cbist_pkg::PAT_TAPS,
    parameter logic [W-1:0] SEED  = cbist_pkg::PAT_SEED,
    parameter int           LIM_W = cbist_pkg::LIMIT_W,
    parameter int           CNT_W = cbist_pkg::COUNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LIM_W-1:0] cfg_wait_limit,
    input  logic [CNT_W-1:0] cfg_num_patterns,
    input  logic [W-1:0]     func_in,
    input  logic [W-1:0]     cut_resp,
    output logic [W-1:0]     cut_in,
    output logic             test_sel,
    output logic [W-1:0]     signature,
    output logic             done
);
    import cbist_pkg::*;

    typedef struct packed {
        phase_e           phase;
        logic             sel;
        logic [LIM_W-1:0] lim;
        logic [CNT_W-1:0] num;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t        st_d, st_q;
    logic [W-1:0] pattern;
    logic         running, apply, miss, expire;
    logic [CNT_W-1:0] cnt_inc;

    assign running = (st_q.phase == PH_RUN) && !start;
    assign cut_in  = st_q.sel ? pattern : func_in;
    assign apply   = running && (cut_in == pattern);
    assign miss    = running && !apply;
    assign cnt_inc = st_q.cnt + {{(CNT_W-1){1'b0}}, 1'b1};

    cbist_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .step    (apply),
        .pattern (pattern)
    );

    cbist_misr #(.W(W), .TAPS(TAPS)) u_sig (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .capture (apply),
        .resp    (cut_resp),
        .sig     (signature)
    );

    cbist_wait_timer #(.LIM_W(LIM_W)) u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start || apply),
        .tick   (miss),
        .limit  (st_q.lim),
        .expire (expire)
    );

    always_comb begin
        st_d     = st_q;
        st_d.sel = 1'b0;
        if (start) begin
            st_d.lim   = cfg_wait_limit;
            st_d.num   = cfg_num_patterns;
            st_d.cnt   = '0;
            st_d.phase = (cfg_num_patterns == '0) ? PH_DONE : PH_RUN;
        end else if (apply) begin
            st_d.cnt = cnt_inc;
            if (cnt_inc == st_q.num) st_d.phase = PH_DONE;
        end else if (miss && expire) begin
            st_d.sel = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.sel   <= 1'b0;
            st_q.lim   <= '0;
            st_q.num   <= '0;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign test_sel = st_q.sel;
    assign done     = (st_q.phase == PH_DONE);

    // R7: forced selection lasts one cycle
    p_sel_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sel |=> !st_q.sel);

    // R7: a forced cycle always steps the generator
    p_forced_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sel && st_q.phase == PH_RUN && !start) |=> pattern != $past(pattern));

    // R9: once done, the signature and done hold until a new start
    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(signature) && !test_sel));

    // R9: applied count never reaches the target while running
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RUN) |-> st_q.cnt < st_q.num);

    // R11: a miss does not touch the signature
    p_miss_no_sig_r11: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> $stable(signature));
endmodule

// File: tb/cbist_match_ctrl_tb.sv
module cbist_match_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] cfg_wait_limit = 8'd0;
    logic [15:0] cfg_num_patterns = 16'd0;
    logic [7:0] func_in = 8'h3C;
    logic [7:0] cut_resp, cut_in, signature;
    logic       test_sel, done;

    always #4 clk = ~clk;

    function automatic logic [7:0] stepf(input logic [7:0] x);
        return {x[6:0], x[7] ^ x[5] ^ x[4] ^ x[3]};
    endfunction

    function automatic logic [7:0] cutf(input logic [7:0] x);
        return {x[6:0], x[7]} ^ 8'h5A;
    endfunction

    assign cut_resp = cutf(cut_in);

    cbist_match_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_wait_limit(cfg_wait_limit), .cfg_num_patterns(cfg_num_patterns),
        .func_in(func_in), .cut_resp(cut_resp), .cut_in(cut_in),
        .test_sel(test_sel), .signature(signature), .done(done)
    );

    typedef struct {
        logic [7:0] cut;
        logic       sel;
        logic [7:0] sig;
        logic       dn;
        string      tag;
    } exp_t;
    exp_t q[$];

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // model state
    logic [7:0]  m_pat = 8'h01, m_sig = 8'h00;
    logic        m_sel = 0, m_done = 0, m_run = 0;
    int          m_wait = 0, m_cnt = 0, m_lim = 0, m_num = 0;
    logic [7:0]  lcg = 8'h37;

    task automatic chk8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input logic [7:0] f, input logic st, input string tag);
        exp_t e;
        logic [7:0] ci;
        @(negedge clk);
        func_in = f;
        start   = st;
        ci = m_sel ? m_pat : f;
        e.cut = ci; e.sel = m_sel; e.sig = m_sig; e.dn = m_done; e.tag = tag;
        q.push_back(e);
        if (st) begin
            m_pat = 8'h01; m_sig = 8'h00; m_sel = 0; m_wait = 0; m_cnt = 0;
            m_lim = int'(cfg_wait_limit); m_num = int'(cfg_num_patterns);
            m_done = (m_num == 0); m_run = (m_num != 0);
        end else if (m_run) begin
            if (ci == m_pat) begin
                m_sig = stepf(m_sig) ^ cutf(ci);
                m_pat = stepf(m_pat);
                m_cnt++; m_wait = 0; m_sel = 0;
                if (m_cnt == m_num) begin m_done = 1; m_run = 0; end
            end else if (m_wait + 1 >= m_lim) begin
                m_sel = 1; m_wait = 0;
            end else begin
                m_wait++; m_sel = 0;
            end
        end else begin
            m_sel = 0;
        end
    endtask

    task automatic hit(input string tag);  cyc(m_pat, 1'b0, tag); endtask
    task automatic miss(input string tag); cyc(m_pat ^ 8'hFF, 1'b0, tag); endtask
    task automatic go(input int lim, input int num, input string tag);
        cfg_wait_limit = 8'(lim); cfg_num_patterns = 16'(num);
        cyc(8'hA5, 1'b1, tag);
    endtask

    // monitor
    always @(negedge clk) begin
        #2;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk8(e.tag, "cut_in", cut_in, e.cut);
            chk8(e.tag, "test_sel", {7'd0, test_sel}, {7'd0, e.sel});
            chk8(e.tag, "signature", signature, e.sig);
            chk8(e.tag, "done", {7'd0, done}, {7'd0, e.dn});
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R1 reset state
        chk8("R1", "done", {7'd0, done}, 8'd0);
        chk8("R1", "test_sel", {7'd0, test_sel}, 8'd0);
        chk8("R1", "signature", signature, 8'h00);
        chk8("R1", "cut_in", cut_in, 8'h3C);
        @(negedge clk); rst_n = 1'b1;

        // A: L=4, N=6
        go(4, 6, "R10");
        hit("R3"); hit("R4");
        miss("R11"); miss("R11"); miss("R11"); miss("R6");
        miss("R7");                 // forced cycle, func ignored
        miss("R7");                 // back to normal
        miss("R8"); hit("R8");
        miss("R8"); miss("R8"); miss("R8"); miss("R8");
        miss("R6");                 // forced
        hit("R5");                  // sixth vector -> done
        cyc(8'h11, 1'b0, "R9"); cyc(8'hFE, 1'b0, "R9"); miss("R9");
        cyc(8'h42, 1'b0, "R2");

        // B: N=0
        go(3, 0, "R10");
        cyc(8'h77, 1'b0, "R10"); cyc(8'h01, 1'b0, "R9");

        // C: L=0 means one miss then force
        go(0, 3, "R6");
        miss("R6"); miss("R7"); miss("R6"); miss("R7"); miss("R6"); miss("R7");
        cyc(8'h00, 1'b0, "R9");

        // D: restart mid-run
        go(3, 10, "R10");
        hit("R3"); hit("R3"); hit("R3");
        go(5, 2, "R10");
        hit("R4"); hit("R5");
        cyc(8'h5C, 1'b0, "R9");

        // E: pseudo-random traffic with occasional matches
        go(2, 20, "R2");
        for (int i = 0; i < 80; i++) begin
            lcg = lcg * 8'd29 + 8'd71;
            if (lcg[2:0] == 3'd5) hit("R3");
            else cyc(lcg, 1'b0, "R11");
        end
        cyc(8'h00, 1'b0, "R9");

        repeat (2) @(negedge clk);
        #3;
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule